// File: doc/BRIEF.md
# Parity-Framed Proximity ID Serializer

This block turns a 40-bit identifier into the 64-bit frame that a low-frequency proximity tag sends, and drives that frame out as a Manchester-coded bit stream on one pin. The frame opens with a run of nine ones. The identifier follows in rows of four bits, and every row carries its own even-parity bit. Four column-parity bits and a zero stop bit close the frame. All of it is computed in hardware from the identifier alone.

A host presents an identifier and a rate value, then pulses `load`. While `enable` is high the serializer sends the current frame again and again with no gap between frames. A new identifier replaces the current one only at a frame boundary. `done` pulses once when the first full frame built from a new load has gone out. The bit period is counted in cycles of the carrier clock that drives `clk`.

Top module: `prox_id_serializer`

## Requirements
- R1: After reset, `busy`, `done` and `mod_out` are all 0.
- R2: A frame is sent from its first bit to its 64th. Bits 1 to 9 are 1. Next come ten groups of five bits. Group r carries identifier bits 39-4r down to 36-4r, highest first, and then the even parity (XOR) of those four bits.
- R3: Bits 60 to 63 are column parities. Bit 60+c is the XOR, over all ten rows, of the row bit sent in position c of its row, where c runs from 0 (first sent) to 3. Bit 64 is a 0 stop bit.
- R4: Each frame bit is sent as two equal half-bits. `mod_out` holds the bit value in the first half-bit and the complement in the second. `mod_out` is 0 whenever `busy` is 0.
- R5: A half-bit lasts floor(rate/2) clock cycles. A rate of 0 means a 64-cycle bit period, so 32 cycles per half-bit. A rate of 1 gives one-cycle half-bits.
- R6: When `load` is sampled high while the block is idle with `enable` high, `busy` rises and the first half-bit of the frame starts on the second rising edge after that sample.
- R7: While `enable` stays high, the frame repeats back to back. The next frame's first half-bit follows the last half-bit of the stop bit with no gap.
- R8: A `load` during a frame does not alter that frame. The new identifier and rate take effect from the next frame boundary.
- R9: `done` is high for exactly one cycle, in the cycle right after the last half-bit of the first complete frame built from a load. It stays low at every later boundary until another load takes effect.
- R10: When `enable` goes low mid-frame, the frame finishes. `busy` and `mod_out` drop at its boundary. A `load` made while `enable` is low does not start a frame. The frame starts once `enable` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows frames to be sent and repeated |
| load | input | 1 | One-cycle strobe that captures `id_in` and `rate_in` |
| id_in | input | 40 | Identifier to serialize |
| rate_in | input | RATE_W (8) | Bit period in clock cycles; 0 selects 64 |
| busy | output | 1 | A frame is being sent |
| done | output | 1 | One-cycle pulse after the first full frame of a new load |
| mod_out | output | 1 | Manchester-coded frame stream |

## Verification
Each fault inside the block shows up at `mod_out` within one frame. A bad half-bit counter stretches or shrinks every half-bit, starting with the first. A wrong row or column term flips exactly one bit position in every frame. A swap of the frame at the wrong moment changes the stream partway through a frame, or a frame too early. A misplaced announce flag moves or repeats `done` at the next boundary. Comparing whole frames cycle by cycle against the R2 and R3 layout, over many identifiers and rates, therefore catches each such fault by the end of the frame it damages.

// File: rtl/prox_frame_pkg.sv
package prox_frame_pkg;
  localparam int ID_W      = 40;
  localparam int ROW_W     = 4;
  localparam int ROWS      = ID_W / ROW_W;
  localparam int HDR_LEN   = 9;
  localparam int FRAME_LEN = HDR_LEN + ROWS * (ROW_W + 1) + ROW_W + 1;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  typedef logic [ID_W-1:0]      id_t;
  typedef logic [FRAME_LEN-1:0] frame_t;

  // XOR of the bit in row position col (0 = first sent) across all rows
  function automatic logic column_parity(id_t id, int col);
    logic acc;
    acc = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      acc ^= id[ID_W-1-r*ROW_W-col];
    end
    return acc;
  endfunction

  // half-bit length in clock cycles for a given rate value
  function automatic int unsigned half_cycles(int unsigned rate, int unsigned dflt);
    if (rate == 0) return dflt / 2;
    if (rate < 2)  return 1;
    return rate / 2;
  endfunction
endpackage

// File: rtl/prox_frame_builder.sv
module prox_frame_builder
  import prox_frame_pkg::*;
(
  input  id_t    id,
  output frame_t frame
);
  localparam int ROW_BASE = FRAME_LEN - 1 - HDR_LEN;
  localparam int COL_BASE = ROW_BASE - ROWS * (ROW_W + 1);

  assign frame[FRAME_LEN-1 -: HDR_LEN] = '1;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int DST = ROW_BASE - r * (ROW_W + 1);
    localparam int SRC = ID_W - 1 - r * ROW_W;
    assign frame[DST -: ROW_W]  = id[SRC -: ROW_W];
    assign frame[DST - ROW_W]   = ^id[SRC -: ROW_W];
  end

  for (genvar c = 0; c < ROW_W; c++) begin : g_col
    assign frame[COL_BASE - c] = column_parity(id, c);
  end

  assign frame[0] = 1'b0;
endmodule

// File: rtl/prox_bit_timer.sv
module prox_bit_timer #(
  parameter int CNT_W    = 8,
  parameter int IDX_W    = 6,
  parameter int LAST_IDX = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] half_lim,
  output logic [IDX_W-1:0] bit_idx,
  output logic             phase,
  output logic             frame_last
);
  logic [CNT_W-1:0] cnt;
  logic             half_last;

  assign half_last  = (cnt == half_lim - CNT_W'(1));
  assign frame_last = run && half_last && phase && (bit_idx == IDX_W'(LAST_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      phase   <= 1'b0;
      bit_idx <= '0;
    end else if (restart) begin
      cnt     <= '0;
      phase   <= 1'b0;
      bit_idx <= '0;
    end else if (run && half_last) begin
      cnt <= '0;
      if (phase) begin
        phase   <= 1'b0;
        bit_idx <= bit_idx + IDX_W'(1);
      end else begin
        phase <= 1'b1;
      end
    end else if (run) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/prox_id_serializer.sv
module prox_id_serializer
  import prox_frame_pkg::*;
#(
  parameter int RATE_W         = 8,
  parameter int DEFAULT_PERIOD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load,
  input  logic [ID_W-1:0]   id_in,
  input  logic [RATE_W-1:0] rate_in,
  output logic              busy,
  output logic              done,
  output logic              mod_out
);
  localparam int LAST_IDX = FRAME_LEN - 1;

  logic              active, pend_vld, cur_vld, announce, done_q;
  id_t               pend_id;
  logic [RATE_W-1:0] pend_rate, pend_half, cur_half;
  frame_t            pend_frame, cur_frame;

  // named internal events
  logic              take_w, swap_w, frame_end_w, phase_w;
  logic [IDX_W-1:0]  bit_idx_w;

  prox_frame_builder bld_i (
    .id    (pend_id),
    .frame (pend_frame)
  );

  assign pend_half = RATE_W'(half_cycles(32'(pend_rate), DEFAULT_PERIOD));

  prox_bit_timer #(
    .CNT_W    (RATE_W),
    .IDX_W    (IDX_W),
    .LAST_IDX (LAST_IDX)
  ) tmr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (active),
    .restart    (take_w),
    .half_lim   (cur_half),
    .bit_idx    (bit_idx_w),
    .phase      (phase_w),
    .frame_last (frame_end_w)
  );

  assign take_w = (!active && enable && (pend_vld || cur_vld)) || (frame_end_w && enable);
  assign swap_w = take_w && pend_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      pend_vld  <= 1'b0;
      cur_vld   <= 1'b0;
      announce  <= 1'b0;
      done_q    <= 1'b0;
      pend_id   <= '0;
      pend_rate <= '0;
      cur_half  <= '0;
      cur_frame <= '0;
    end else begin
      if (load) begin
        pend_id   <= id_in;
        pend_rate <= rate_in;
      end
      if (load)        pend_vld <= 1'b1;
      else if (swap_w) pend_vld <= 1'b0;
      if (swap_w) begin
        cur_frame <= pend_frame;
        cur_half  <= pend_half;
        cur_vld   <= 1'b1;
      end
      if (take_w)           active <= 1'b1;
      else if (frame_end_w) active <= 1'b0;
      done_q <= frame_end_w && announce;
      if (swap_w)           announce <= 1'b1;
      else if (frame_end_w) announce <= 1'b0;
    end
  end

  assign busy    = active;
  assign done    = done_q;
  assign mod_out = active & (cur_frame[IDX_W'(LAST_IDX) - bit_idx_w] ^ phase_w);
endmodule

// File: rtl/prox_id_serializer_chk.sv
module prox_id_serializer_chk
  import prox_frame_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             busy,
  input logic             done,
  input logic             mod_out,
  input logic             frame_end,
  input logic             announce,
  input logic             phase,
  input logic [IDX_W-1:0] bit_idx,
  input frame_t           cur_frame
);
  assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mod_out);

  assert_half_invert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase && $past(busy) && !$past(phase)) |-> (mod_out != $past(mod_out)));

  assert_header_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx < IDX_W'(HDR_LEN)) |-> (mod_out == !phase));

  assert_stop_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx == IDX_W'(FRAME_LEN-1)) |-> (mod_out == phase));

  assert_frame_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |=> $stable(cur_frame));

  assert_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && enable) |=> (busy && bit_idx == '0 && !phase));

  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && announce) |=> done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_stop_on_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !enable) |=> !busy);
endmodule

bind prox_id_serializer prox_id_serializer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .busy      (busy),
  .done      (done),
  .mod_out   (mod_out),
  .frame_end (frame_end_w),
  .announce  (announce),
  .phase     (phase_w),
  .bit_idx   (bit_idx_w),
  .cur_frame (cur_frame)
);

// File: tb/prox_id_serializer_tb.sv
module prox_id_serializer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        load = 1'b0;
  logic [39:0] id_in = '0;
  logic [7:0]  rate_in = '0;
  logic        busy, done, mod_out;

  int n_total = 0;
  int n_pass  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prox_id_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load(load),
    .id_in(id_in), .rate_in(rate_in),
    .busy(busy), .done(done), .mod_out(mod_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_pass, n_total);
  endtask

  // frame from the layout rules, assembled bit by bit
  function automatic logic [63:0] exp_frame(logic [39:0] id);
    logic [63:0] v;
    logic p;
    v = '0;
    for (int i = 0; i < 9; i++) v = {v[62:0], 1'b1};
    for (int r = 0; r < 10; r++) begin
      p = 1'b0;
      for (int b = 0; b < 4; b++) begin
        v = {v[62:0], id[39-4*r-b]};
        p ^= id[39-4*r-b];
      end
      v = {v[62:0], p};
    end
    for (int c = 0; c < 4; c++) begin
      p = 1'b0;
      for (int r = 0; r < 10; r++) p ^= id[39-4*r-c];
      v = {v[62:0], p};
    end
    v = {v[62:0], 1'b0};
    return v;
  endfunction

  function automatic int exp_half(logic [7:0] rate);
    if (rate == 8'd0) return 32;
    if (rate == 8'd1) return 1;
    return int'(rate) >> 1;
  endfunction

  task automatic do_load(input logic [39:0] id, input logic [7:0] rate);
    load = 1'b1; id_in = id; rate_in = rate;
    @(negedge clk);
    load = 1'b0;
  endtask

  // Called at the negedge of a frame's first cycle; returns at the first
  // cycle after the frame.
  task automatic check_frame(input logic [39:0] id, input logic [7:0] rate,
                             input bit ml, input logic [39:0] ml_id,
                             input logic [7:0] ml_rate, input bit dis,
                             input string req);
    logic [63:0] f;
    int h, cyc, bad, bad_cyc, done_bad;
    logic exp_m, act_m;
    f = exp_frame(id);
    h = exp_half(rate);
    cyc = 0; bad = 0; bad_cyc = -1; done_bad = 0; exp_m = 0; act_m = 0;
    for (int b = 0; b < 64; b++) begin
      for (int p = 0; p < 2; p++) begin
        for (int k = 0; k < h; k++) begin
          if (!busy || mod_out !== (f[63-b] ^ p[0])) begin
            if (bad == 0) begin
              bad_cyc = cyc; act_m = mod_out; exp_m = f[63-b] ^ p[0];
            end
            bad++;
          end
          if (cyc > 0 && done !== 1'b0) done_bad++;
          if (ml && cyc == 10) begin load = 1'b1; id_in = ml_id; rate_in = ml_rate; end
          if (ml && cyc == 11) load = 1'b0;
          if (dis && cyc == 10) enable = 1'b0;
          @(negedge clk);
          cyc++;
        end
      end
    end
    check(bad == 0, req, $sformatf("frame id %h rate %0d first bad cycle %0d mod_out",
          id, rate, bad_cyc), act_m, exp_m);
    check(done_bad == 0, "R9", "done inside frame count", done_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
    $finish;
  end

  initial begin
    logic [39:0] ida, idb, idc, idd, ide, idf, nxt;
    ida = 40'h06_0012_3456;
    idb = 40'hFF_FFFF_FFFF;
    idc = 40'h00_0000_0000;
    idd = 40'hA5_5AC3_3C0F;
    ide = 40'h12_3456_789A;
    idf = 40'hDE_ADBE_EF01;

    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1", "busy after reset", busy, 0);
    check(done === 1'b0, "R1", "done after reset", done, 0);
    check(mod_out === 1'b0, "R1", "mod_out after reset", mod_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: start latency from an idle load
    enable = 1'b1;
    do_load(ida, 8'd4);
    check(busy === 1'b0, "R6", "busy one cycle after load", busy, 0);
    @(negedge clk);
    check(busy === 1'b1, "R6", "busy two edges after load", busy, 1);
    check_frame(ida, 8'd4, 0, '0, '0, 0, "R2 R3 R4 R6");
    check(done === 1'b1, "R9", "done after first frame", done, 1);

    // R7 repeat, with R8 load in the middle of it
    check_frame(ida, 8'd4, 1, idb, 8'd0, 0, "R7 R8");
    check(done === 1'b0, "R9", "done after repeated frame", done, 0);
    check(busy === 1'b1, "R7", "busy across boundary", busy, 1);

    check_frame(idb, 8'd0, 1, idc, 8'd7, 0, "R5 R8 default rate");
    check(done === 1'b1, "R9", "done after rate-0 frame", done, 1);
    check_frame(idc, 8'd7, 1, idd, 8'd1, 0, "R5 odd rate");
    check(done === 1'b1, "R9", "done after rate-7 frame", done, 1);
    check_frame(idd, 8'd1, 1, 40'h80_0000_0000, 8'd2, 0, "R5 rate one");
    check(done === 1'b1, "R9", "done after rate-1 frame", done, 1);

    // walking-one sweep over every identifier position (R2 R3)
    for (int i = 39; i >= 0; i--) begin
      nxt = (i > 0) ? (40'h1 << (i-1)) : ide;
      check_frame(40'h1 << i, 8'd2, 1, nxt, (i > 0) ? 8'd2 : 8'd3, 0, "R2 R3 walking one");
      check(done === 1'b1, "R9", "done after sweep frame", done, 1);
    end

    // R10: disable mid-frame
    check_frame(ide, 8'd3, 0, '0, '0, 1, "R10 frame completes");
    check(done === 1'b1, "R9", "done after last frame", done, 1);
    check(busy === 1'b0, "R10", "busy after disable boundary", busy, 0);
    begin
      int quiet_bad;
      quiet_bad = 0;
      do_load(idf, 8'd2);
      for (int k = 0; k < 20; k++) begin
        if (busy !== 1'b0 || mod_out !== 1'b0) quiet_bad++;
        @(negedge clk);
      end
      check(quiet_bad == 0, "R10", "activity while disabled", quiet_bad, 0);
    end
    enable = 1'b1;
    @(negedge clk);
    check_frame(idf, 8'd2, 0, '0, '0, 1, "R10 start on enable");
    check(done === 1'b1, "R9", "done after re-enabled frame", done, 1);
    check(busy === 1'b0 && mod_out === 1'b0, "R4", "idle output", mod_out, 0);

    report();
    $finish;
  end
endmodule